// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a bank of I/O pins. Software reaches it through a small synchronous register bus. Each pin can work as a general-purpose input or output, or it can be lent to an on-chip peripheral. Four word registers hold the per-pin settings: the pin assignment, the direction, the open-drain enable and the output data latch. Reading the data word gives the live pin levels after a two-flop synchronizer. It does not return what software last wrote.

When a pin is lent to a peripheral, its direction bit decides what that pin does. With direction 0 it carries the pin level into the peripheral input of the same index. With direction 1 it drives the peripheral output of that index onto the pin. A peripheral input that no pin feeds gets a fixed default value. One input is an exception: its default is a loopback of another peripheral output, like a serial master-in that hears master-out while it has no pin. Open-drain mode works in both general-purpose and peripheral mode. In that mode the pin is only pulled low and is released for a 1.

Top module: `gpio_mux_port`

## Requirements
- R1: A write with `bus_wr` high loads `bus_wdata` into the register chosen by `bus_addr`: 0 selects assignment, 1 selects direction, 2 selects open-drain and 3 selects the output latch. `bus_rdata` is registered. It shows the register chosen by `bus_addr` one clock edge later. Addresses 0, 1 and 2 read back the stored value.
- R2: In general-purpose mode (assignment bit 0), direction bit 0 keeps `pin_oe` low. Direction bit 1 sets `pin_oe` high, unless open-drain releases the pin.
- R3: Reset clears the assignment, direction, open-drain and latch registers and `bus_rdata`, so every pin comes up as a general-purpose input with `pin_oe` at 0.
- R4: A general-purpose output drives its latch bit on `pin_out`. The latch keeps its value while the pin is an input, and it appears on the pin once the pin becomes an output. `pin_out` is 0 whenever `pin_oe` is 0.
- R5: Reading address 3 returns `pin_in` after two synchronizer flops plus the read register. A stable pin level appears on `bus_rdata` three edges after it is applied. The value read is the pin level, whatever the latch holds.
- R6: With its open-drain bit set, a pin that would drive 0 gives `pin_oe`=1 with `pin_out`=0. A pin that would drive 1 gives `pin_oe`=0.
- R7: With assignment 1 and direction 0, `per_in[i]` carries the synchronized `pin_in[i]`, and `pin_oe[i]` is 0.
- R8: With assignment 1 and direction 1, the pin drives `per_out[i]`.
- R9: A peripheral input whose pin is not routed to it (assignment 0 or direction 1) takes its bit of the default vector `DFLT_IN`. The default vector is `18'h0A5A4`.
- R10: Input `LOOP_DST` (default 3) is the exception: while it is not routed, it follows `per_out[LOOP_SRC]` (default 2) with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Value driven toward the pads |
| pin_oe | output | NPINS | Per-pin drive enable |
| per_out | input | NPINS | Peripheral output functions |
| per_in | output | NPINS | Peripheral input functions |

## Verification
Random patterns mix the four registers, so all eight combinations of assignment, direction and open-drain occur on different pins at the same time. Each pin is then compared against a bench model. This separates the latch source from the peripheral source for the driven value. It also separates push-pull from released drive, and routed peripheral inputs from defaulted ones. Directed cases cover three points that random patterns can hide. The latch is loaded while the pin is an input, and it must appear later. A readback must return pin levels that differ from the latch. The loopback input must track the peripheral output while it is unrouted, and must switch to the pin once it is routed.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
   typedef enum logic [1:0] {
      REG_ASSIGN = 2'd0,
      REG_DIR    = 2'd1,
      REG_ODRAIN = 2'd2,
      REG_DATA   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
   parameter int WIDTH  = 18,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_mux_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
   import gpio_mux_pkg::*;
#(
   parameter int NPINS = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   input  logic [NPINS-1:0] pin_sync,
   output logic [NPINS-1:0] bus_rdata,
   output logic [NPINS-1:0] par_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] od_q,
   output logic [NPINS-1:0] lat_q
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= '0;
         dir_q <= '0;
         od_q  <= '0;
         lat_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            REG_ASSIGN: par_q <= bus_wdata;
            REG_DIR:    dir_q <= bus_wdata;
            REG_ODRAIN: od_q  <= bus_wdata;
            default:    lat_q <= bus_wdata;
         endcase
      end
   end

   logic [NPINS-1:0] rd_mux;
   always_comb begin
      case (sel)
         REG_ASSIGN: rd_mux = par_q;
         REG_DIR:    rd_mux = dir_q;
         REG_ODRAIN: rd_mux = od_q;
         default:    rd_mux = pin_sync;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/gpio_mux_slice.sv
module gpio_mux_slice #(
   parameter bit DFLT    = 1'b0,
   parameter bit IS_LOOP = 1'b0
) (
   input  logic par,
   input  logic dir,
   input  logic od,
   input  logic lat,
   input  logic pin_s,
   input  logic per_o,
   input  logic loop_src,
   output logic pin_out,
   output logic pin_oe,
   output logic per_i
);
   logic drive, val, routed, idle_val;

   assign drive  = dir;
   assign val    = par ? per_o : lat;
   assign routed = par & ~dir;

   always_comb begin
      if (od) begin
         pin_oe  = drive & ~val;
         pin_out = 1'b0;
      end else begin
         pin_oe  = drive;
         pin_out = drive & val;
      end
   end

   generate
      if (IS_LOOP) begin : g_loop
         assign idle_val = loop_src;
      end else begin : g_const
         assign idle_val = DFLT;
      end
   endgenerate

   assign per_i = routed ? pin_s : idle_val;
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
   parameter int              NPINS    = 18,
   parameter int              SYNC_STG = 2,
   parameter logic [NPINS-1:0] DFLT_IN = 18'h0A5A4,
   parameter int              LOOP_SRC = 2,
   parameter int              LOOP_DST = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   input  logic [NPINS-1:0] per_out,
   output logic [NPINS-1:0] per_in
);
   generate
      if (NPINS < 1 || NPINS > 32) begin : g_bad_n
         $error("gpio_mux_port: NPINS out of range 1..32");
      end
      if (LOOP_SRC >= NPINS || LOOP_DST >= NPINS || LOOP_SRC == LOOP_DST) begin : g_bad_loop
         $error("gpio_mux_port: bad loopback indices");
      end
   endgenerate

   logic [NPINS-1:0] par_q, dir_q, od_q, lat_q, pin_s;

   gpio_mux_sync #(.WIDTH(NPINS), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_s)
   );

   gpio_mux_regs #(.NPINS(NPINS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pin_sync  (pin_s),
      .bus_rdata (bus_rdata),
      .par_q     (par_q),
      .dir_q     (dir_q),
      .od_q      (od_q),
      .lat_q     (lat_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_mux_slice #(
         .DFLT    (DFLT_IN[i]),
         .IS_LOOP (i == LOOP_DST)
      ) u_slice (
         .par      (par_q[i]),
         .dir      (dir_q[i]),
         .od       (od_q[i]),
         .lat      (lat_q[i]),
         .pin_s    (pin_s[i]),
         .per_o    (per_out[i]),
         .loop_src (per_out[LOOP_SRC]),
         .pin_out  (pin_out[i]),
         .pin_oe   (pin_oe[i]),
         .per_i    (per_in[i])
      );
   end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
   parameter int               NPINS    = 18,
   parameter logic [NPINS-1:0] DFLT_IN  = '0,
   parameter int               LOOP_SRC = 2,
   parameter int               LOOP_DST = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [NPINS-1:0] bus_wdata,
   input logic [NPINS-1:0] bus_rdata,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] per_out,
   input logic [NPINS-1:0] per_in,
   input logic [NPINS-1:0] par_q,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] od_q,
   input logic [NPINS-1:0] lat_q,
   input logic [NPINS-1:0] pin_s
);
   logic [NPINS-1:0] idle_mask;
   assign idle_mask = ~(par_q & ~dir_q);

   AST_WRITE_ASSIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> par_q == $past(bus_wdata)); // R1
   AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~dir_q) == '0); // R2
   AST_GPIO_LATCH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~par_q & ~od_q) & (pin_out ^ lat_q)) == '0); // R4
   AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd3) |=> bus_rdata == $past(pin_s)); // R5
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (od_q & pin_oe & pin_out) == '0); // R6
   AST_DEDICATED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((par_q & dir_q & ~od_q) & (pin_out ^ per_out)) == '0); // R8
   AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      ((idle_mask & ~(NPINS'(1) << LOOP_DST)) & (per_in ^ DFLT_IN)) == '0); // R9
   AST_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
      idle_mask[LOOP_DST] |-> per_in[LOOP_DST] == per_out[LOOP_SRC]); // R10
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
   .NPINS(NPINS), .DFLT_IN(DFLT_IN), .LOOP_SRC(LOOP_SRC), .LOOP_DST(LOOP_DST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
   .pin_oe(pin_oe), .per_out(per_out), .per_in(per_in), .par_q(par_q),
   .dir_q(dir_q), .od_q(od_q), .lat_q(lat_q), .pin_s(pin_s)
);

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
   localparam int N = 18;
   localparam logic [N-1:0] DFLT = 18'h0A5A4;
   localparam int LSRC = 2;
   localparam int LDST = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [N-1:0] bus_wdata = '0, pin_in = '0, per_out = '0;
   logic [N-1:0] bus_rdata, pin_out, pin_oe, per_in;

   logic [N-1:0] m_par = '0, m_dir = '0, m_od = '0, m_lat = '0;
   int total = 0, bad = 0;
   int unsigned seed = 32'd1357;

   always #2.5 clk = ~clk;

   gpio_mux_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .per_out(per_out), .per_in(per_in)
   );

   function automatic logic [N-1:0] exp_oe();
      logic [N-1:0] v = m_par ? '0 : '0;
      for (int i = 0; i < N; i++) begin
         logic val = m_par[i] ? per_out[i] : m_lat[i];
         v[i] = m_od[i] ? (m_dir[i] & ~val) : m_dir[i];
      end
      return v;
   endfunction

   function automatic logic [N-1:0] exp_out();
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) begin
         logic val = m_par[i] ? per_out[i] : m_lat[i];
         v[i] = m_od[i] ? 1'b0 : (m_dir[i] & val);
      end
      return v;
   endfunction

   function automatic logic [N-1:0] exp_pin_in();
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) begin
         if (m_par[i] && !m_dir[i]) v[i] = pin_in[i];
         else if (i == LDST)        v[i] = per_out[LSRC];
         else                       v[i] = DFLT[i];
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         2'd0: m_par = d;
         2'd1: m_dir = d;
         2'd2: m_od  = d;
         default: m_lat = d;
      endcase
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic settle();
      bus_addr = 2'd3;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_all(input string tag);
      check({tag, " R2/R4/R6/R8 oe"}, pin_oe, exp_oe());
      check({tag, " R4/R8 out"}, pin_out, exp_out());
      check({tag, " R7/R9/R10 per_in"}, per_in, exp_pin_in());
      check({tag, " R5 readback"}, bus_rdata, pin_in);
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [N-1:0] r;
      repeat (3) @(negedge clk);
      // R3 reset state
      check("R3 oe in reset", pin_oe, '0);
      check("R3 rdata in reset", bus_rdata, '0);
      rst_n = 1'b1;
      rd(2'd0, r); check("R3 assign cleared", r, '0);
      rd(2'd1, r); check("R3 dir cleared", r, '0);
      rd(2'd2, r); check("R3 odrain cleared", r, '0);
      check("R3 inputs default R9", per_in, exp_pin_in());

      // R1 register readback
      wr(2'd0, 18'h2AAAA); rd(2'd0, r); check("R1 assign rb", r, 18'h2AAAA);
      wr(2'd1, 18'h15555); rd(2'd1, r); check("R1 dir rb", r, 18'h15555);
      wr(2'd2, 18'h3F00F); rd(2'd2, r); check("R1 odrain rb", r, 18'h3F00F);
      wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '0);

      // R4 latch loaded while input, then appears
      wr(2'd3, 18'h3C3C3);
      check("R4 hidden while input oe", pin_oe, '0);
      check("R4 hidden while input out", pin_out, '0);
      wr(2'd1, '1);
      check("R4 latch appears", pin_out, 18'h3C3C3);
      check("R2 all driving", pin_oe, '1);

      // R5 readback is pin level, not latch
      pin_in = 18'h05A5A;
      settle();
      check("R5 pins not latch", bus_rdata, 18'h05A5A);

      // R6 open drain
      wr(2'd2, '1);
      check("R6 od oe", pin_oe, ~18'h3C3C3);
      check("R6 od out", pin_out, '0);
      wr(2'd2, '0); wr(2'd1, '0);

      // R10 loopback, then routed
      per_out = '0; per_out[LSRC] = 1'b1;
      #1 check("R10 loop high", {17'd0, per_in[LDST]}, 18'd1);
      per_out[LSRC] = 1'b0;
      #1 check("R10 loop low", {17'd0, per_in[LDST]}, 18'd0);
      pin_in = '0; pin_in[LDST] = 1'b1;
      wr(2'd0, 18'(1) << LDST);
      settle();
      check("R7 routed dst uses pin", {17'd0, per_in[LDST]}, 18'd1);
      wr(2'd0, '0);

      // random mix
      for (int k = 0; k < 300; k++) begin
         logic [N-1:0] v;
         v = N'($urandom(seed)); seed = seed + 1;
         wr(2'($urandom() % 4), v);
         pin_in  = N'($urandom());
         per_out = N'($urandom());
         settle();
         check_all($sformatf("rand%0d", k));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule